// File: doc/BRIEF.md
# I2C Master Serial Clock Generator with Clock Synchronization

This block produces the serial clock of an I2C master from the system clock. A programmable prescaler divides the system clock into a slower count clock. Two divider values then set the number of count-clock periods that SCL stays low and the number that it stays high. Each divider value has a fixed offset added to it, and the size of that offset depends on the prescale setting. The outputs are an open-drain pull-down enable for SCL and two single-cycle ticks. The frame sequencer uses the first tick to change SDA in the middle of the low phase and the second to sample SDA in the middle of the high phase.

The block shares the wire with other devices as a wired-AND clock. If another master pulls SCL low during the high phase, the block drops into its own low phase and counts the low time again from the start. Once its own low count ends, the block releases SCL. It starts timing the high phase only after it sees the line actually high, which lets a slave stretch the clock. As a result, the slowest device on the bus sets the low time and the fastest device sets the high time.

The configuration is captured at the moment the soft-reset enable goes from 0 to 1. Input changes made while the block is enabled have no effect. While the enable is low, or while the sequencer withholds its run request, SCL is left released and no ticks are produced.

Top module: `i2c_scl_gen`

## Requirements
- R1: With nobody else holding SCL, each low phase (scl_drive_low high) lasts (low_div + d) * (psc_val + 1) system clocks. Here d is the offset of R3 and the values are the ones latched under R4.
- R2: With nobody else holding SCL, each released phase lasts (high_div + d) * (psc_val + 1) system clocks.
- R3: The offset d is 7 when psc_val is 0, 6 when psc_val is 1, and 5 for psc_val from 2 to 255.
- R4: psc_val, low_div and high_div are captured in the cycle where enable first reads 1 after reading 0. Changing them while enable stays 1 leaves the waveform unchanged until enable is taken to 0 and back to 1.
- R5: While enable is 0, scl_drive_low and both ticks are 0 from the next clock onward, and stay 0 whatever run is.
- R6: While run is 0, scl_drive_low and both ticks are 0 from the next clock onward.
- R7: If scl_in falls while the block has released SCL and has seen it high, scl_drive_low rises at the next clock. That low phase then lasts the full R1 length, counted from that clock.
- R8: After its own low count ends, the block keeps SCL released and emits no sample tick for as long as scl_in stays low. When scl_in has been seen high, the block counts high_div + d prescaled periods and then drives low again. With psc_val = 0, scl_in reads high on exactly high_div + d - 1 falling-edge samples before scl_drive_low reads 1 again.
- R9: tick_change pulses for exactly one clock per low phase. It is the last clock of prescaled period number floor((low_div + d) / 2) + 1 of that phase, so with no stretching it falls at clock index (floor((low_div + d)/2) + 1) * (psc_val + 1) - 1 counted from 0 at the first low clock.
- R10: tick_sample pulses for exactly one clock per high phase, at index (floor((high_div + d)/2) + 1) * (psc_val + 1) - 1 counted from 0 at the first released clock when no one stretches.
- R11: The two ticks never pulse in the same clock. tick_change pulses only while scl_drive_low is 1, and tick_sample pulses only while scl_in is 1.
- R12: During synchronous reset, scl_drive_low, tick_change and tick_sample are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Soft-reset release; a 0-to-1 change captures the configuration |
| psc_val | input | 8 | Prescale value; count clock = system clock / (psc_val + 1) |
| low_div | input | 8 | Low-time divider value |
| high_div | input | 8 | High-time divider value |
| run | input | 1 | Clock run request from the frame sequencer |
| scl_in | input | 1 | Filtered SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| tick_change | output | 1 | Mid-low strobe telling the sequencer to update SDA |
| tick_sample | output | 1 | Mid-high strobe telling the sequencer to sample SDA |

## Verification
A low or high count that is off by one, or a wrong offset choice, changes the pulse widths on scl_drive_low in the first SCL period after the run request. A prescaler that keeps its phase across a synchronization event gives a low phase that is shortened by up to one prescaled period. This shows in the first low phase after the foreign pull-down. A wait state that starts counting early shows as a drive-low that comes back while another device still holds the line. Broken configuration capture shows as widths that follow the inputs during an enabled run rather than the values seen at enable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_t;

    localparam int OFS_W = 3;

    // Fixed term added to each divider, chosen by the prescale value.
    function automatic logic [OFS_W-1:0] div_offset(input logic psc_zero, input logic psc_one);
        if (psc_zero) begin
            return 3'd7;
        end else if (psc_one) begin
            return 3'd6;
        end
        return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
    import scl_gen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int DIV_W = 8,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [DIV_W-1:0] low_in,
    input  logic [DIV_W-1:0] high_in,
    output logic             active,
    output logic [PSC_W-1:0] psc_q,
    output logic [CNT_W-1:0] low_last,
    output logic [CNT_W-1:0] low_mid,
    output logic [CNT_W-1:0] high_last,
    output logic [CNT_W-1:0] high_mid
);

    logic [OFS_W-1:0] ofs;
    logic [CNT_W-1:0] low_sum;
    logic [CNT_W-1:0] high_sum;

    assign ofs      = div_offset(psc_in == '0, psc_in == PSC_W'(1));
    assign low_sum  = CNT_W'(low_in)  + CNT_W'(ofs);
    assign high_sum = CNT_W'(high_in) + CNT_W'(ofs);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            psc_q     <= '0;
            low_last  <= '0;
            low_mid   <= '0;
            high_last <= '0;
            high_mid  <= '0;
        end else begin
            active <= enable;
            // Track the inputs only while held in soft reset; freeze once enabled.
            if (!active) begin
                psc_q     <= psc_in;
                low_last  <= low_sum - CNT_W'(1);
                low_mid   <= low_sum >> 1;
                high_last <= high_sum - CNT_W'(1);
                high_mid  <= high_sum >> 1;
            end
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             ptick
);

    logic [PSC_W-1:0] pcnt;

    assign ptick = active && (pcnt == psc);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pcnt <= '0;
        end else if (restart || pcnt == psc) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PSC_W'(1);
        end
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             run,
    input  logic             ptick,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_last,
    input  logic [CNT_W-1:0] low_mid,
    input  logic [CNT_W-1:0] high_last,
    input  logic [CNT_W-1:0] high_mid,
    output phase_t           phase,
    output logic             restart,
    output logic             drive_low,
    output logic             tick_change,
    output logic             tick_sample
);

    logic [CNT_W-1:0] cnt;
    logic             scl_prev;
    logic             sync;
    logic             hi_go;

    // Another device pulled the line down while it was high.
    assign sync    = (phase == PH_HIGH) && scl_prev && !scl_in;
    assign hi_go   = ((phase == PH_HIGH) && !sync) || ((phase == PH_WAIT) && scl_in);
    assign restart = sync;

    assign drive_low   = (phase == PH_LOW);
    assign tick_change = (phase == PH_LOW) && ptick && (cnt == low_mid);
    assign tick_sample = hi_go && ptick && (cnt == high_mid);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            scl_prev <= 1'b1;
        end else begin
            scl_prev <= scl_in;
            if (!enable || !run) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (ptick) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end
                    end
                    PH_LOW: begin
                        if (ptick) begin
                            if (cnt == low_last) begin
                                phase <= PH_WAIT;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    PH_WAIT, PH_HIGH: begin
                        if (sync) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else if (hi_go) begin
                            phase <= PH_HIGH;
                            if (ptick) begin
                                if (cnt == high_last) begin
                                    phase <= PH_LOW;
                                    cnt   <= '0;
                                end else begin
                                    cnt <= cnt + CNT_W'(1);
                                end
                            end
                        end
                    end
                    default: begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [DIV_W-1:0] low_div,
    input  logic [DIV_W-1:0] high_div,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             tick_change,
    output logic             tick_sample
);

    localparam int CNT_W = DIV_W + 1;

    logic             active;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] low_last;
    logic [CNT_W-1:0] low_mid;
    logic [CNT_W-1:0] high_last;
    logic [CNT_W-1:0] high_mid;
    logic             ptick;
    logic             restart;
    phase_t           phase;

    scl_cfg_latch #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .psc_in    (psc_val),
        .low_in    (low_div),
        .high_in   (high_div),
        .active    (active),
        .psc_q     (psc_q),
        .low_last  (low_last),
        .low_mid   (low_mid),
        .high_last (high_last),
        .high_mid  (high_mid)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .restart (restart),
        .psc     (psc_q),
        .ptick   (ptick)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .run         (run),
        .ptick       (ptick),
        .scl_in      (scl_in),
        .low_last    (low_last),
        .low_mid     (low_mid),
        .high_last   (high_last),
        .high_mid    (high_mid),
        .phase       (phase),
        .restart     (restart),
        .drive_low   (scl_drive_low),
        .tick_change (tick_change),
        .tick_sample (tick_sample)
    );

endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk
    import scl_gen_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   enable,
    input logic   run,
    input logic   scl_in,
    input logic   scl_drive_low,
    input logic   tick_change,
    input logic   tick_sample,
    input phase_t phase
);

    // R5
    enable_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_drive_low && !tick_change && !tick_sample));

    // R6
    run_release_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!scl_drive_low && !tick_change && !tick_sample));

    // R11
    tick_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick_change && tick_sample));

    // R11
    change_in_low_chk: assert property (@(posedge clk) disable iff (rst)
        tick_change |-> scl_drive_low);

    // R11
    sample_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        tick_sample |-> scl_in);

    // R7
    sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH && !scl_in && run && enable) |=> (phase == PH_LOW && scl_drive_low));

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && !scl_in && run && enable) |=> (phase == PH_WAIT && !scl_drive_low));

endmodule

bind i2c_scl_gen scl_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .run           (run),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .tick_change   (tick_change),
    .tick_sample   (tick_sample),
    .phase         (phase)
);

// File: tb/i2c_scl_gen_tb.sv
module i2c_scl_gen_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [7:0] psc_val;
    logic [7:0] low_div;
    logic [7:0] high_div;
    logic       run;
    logic       ext_low;
    logic       scl_in;
    logic       scl_drive_low;
    logic       tick_change;
    logic       tick_sample;

    int nrun  = 0;
    int nfail = 0;

    // Wired-AND line: low if this block or another device pulls it down.
    assign scl_in = !(scl_drive_low || ext_low);

    always #10ns clk = ~clk;

    i2c_scl_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .psc_val       (psc_val),
        .low_div       (low_div),
        .high_div      (high_div),
        .run           (run),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .tick_change   (tick_change),
        .tick_sample   (tick_sample)
    );

    // {psc, low divider, high divider}
    localparam logic [23:0] VEC [5] = '{
        {8'd0,   8'd3, 8'd2},
        {8'd1,   8'd0, 8'd0},
        {8'd2,   8'd4, 8'd1},
        {8'd3,   8'd1, 8'd5},
        {8'd255, 8'd0, 8'd0}
    };

    function automatic int ofs(input int p);
        return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nrun++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic configure(input int p, input int l, input int h);
        @(negedge clk);
        enable   = 1'b0;
        run      = 1'b0;
        psc_val  = 8'(p);
        low_div  = 8'(l);
        high_div = 8'(h);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        run    = 1'b1;
    endtask

    // Wait for the start of a low phase, then measure one low and one high phase.
    task automatic measure(output int lo_n, output int hi_n, output int tc_idx,
                           output int ts_idx, output int tc_cnt, output int ts_cnt);
        int guard;
        lo_n = 0; hi_n = 0; tc_idx = -1; ts_idx = -1; tc_cnt = 0; ts_cnt = 0;
        guard = 0;
        @(negedge clk);
        while (scl_drive_low && guard < 20000) begin @(negedge clk); guard++; end
        while (!scl_drive_low && guard < 20000) begin @(negedge clk); guard++; end
        while (scl_drive_low && guard < 20000) begin
            if (tick_change) begin tc_idx = lo_n; tc_cnt++; end
            if (tick_sample) ts_cnt++;
            lo_n++; guard++;
            @(negedge clk);
        end
        while (!scl_drive_low && guard < 20000) begin
            if (tick_sample) begin ts_idx = hi_n; ts_cnt++; end
            if (tick_change) tc_cnt++;
            hi_n++; guard++;
            @(negedge clk);
        end
        if (guard >= 20000) check(1'b0, "measure guard", guard, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        int lo, hi, tci, tsi, tcc, tsc, bad, p, l, h, lt, ht;
        rst = 1'b1; enable = 1'b1; run = 1'b1; ext_low = 1'b0;
        psc_val = 8'd0; low_div = 8'd0; high_div = 8'd0;

        // R12: outputs quiet during reset
        bad = 0;
        repeat (6) begin
            @(negedge clk);
            if (scl_drive_low || tick_change || tick_sample) bad++;
        end
        check(bad == 0, "R12 reset quiet", bad, 0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk: R1, R2, R3, R9, R10
        foreach (VEC[i]) begin
            p = int'(VEC[i][23:16]); l = int'(VEC[i][15:8]); h = int'(VEC[i][7:0]);
            lt = l + ofs(p); ht = h + ofs(p);
            configure(p, l, h);
            measure(lo, hi, tci, tsi, tcc, tsc);
            check(lo == lt * (p + 1), "R1 R3 low length", lo, lt * (p + 1));
            check(hi == ht * (p + 1), "R2 R3 high length", hi, ht * (p + 1));
            check(tci == (lt / 2 + 1) * (p + 1) - 1, "R9 change tick index", tci, (lt / 2 + 1) * (p + 1) - 1);
            check(tsi == (ht / 2 + 1) * (p + 1) - 1, "R10 sample tick index", tsi, (ht / 2 + 1) * (p + 1) - 1);
            check(tcc == 1 && tsc == 1, "R9 R10 one tick each", tcc * 10 + tsc, 11);
        end

        // R5: held in soft reset with run requested
        @(negedge clk); enable = 1'b0; run = 1'b1;
        @(negedge clk);
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (scl_drive_low || tick_change || tick_sample) bad++;
        end
        check(bad == 0, "R5 soft reset quiet", bad, 0);

        // R6: enabled but not running
        configure(0, 3, 2);
        @(negedge clk); run = 1'b0;
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (scl_drive_low || tick_change || tick_sample) bad++;
        end
        check(bad == 0, "R6 idle quiet", bad, 0);

        // R6: run dropped in the middle of a low phase
        run = 1'b1;
        while (!scl_drive_low) @(negedge clk);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R6 release after run drop", int'(scl_drive_low), 0);

        // R5: enable dropped in the middle of a low phase
        run = 1'b1;
        while (!scl_drive_low) @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R5 release after enable drop", int'(scl_drive_low), 0);

        // R4: inputs changed while enabled are ignored
        configure(0, 3, 2);
        @(negedge clk);
        psc_val = 8'd3; low_div = 8'd10; high_div = 8'd10;
        measure(lo, hi, tci, tsi, tcc, tsc);
        check(lo == 10, "R4 low frozen while enabled", lo, 10);
        check(hi == 9, "R4 high frozen while enabled", hi, 9);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        measure(lo, hi, tci, tsi, tcc, tsc);
        check(lo == 60, "R4 low after re-enable", lo, 60);
        check(hi == 60, "R4 high after re-enable", hi, 60);

        // R7: foreign pull-down during the high phase restarts the low count
        configure(1, 1, 4);
        while (!scl_drive_low) @(negedge clk);
        while (scl_drive_low) @(negedge clk);
        repeat (4) @(negedge clk);
        ext_low = 1'b1;
        @(negedge clk);
        check(scl_drive_low, "R7 drive low after foreign fall", int'(scl_drive_low), 1);
        lo = 0;
        while (scl_drive_low && lo < 1000) begin
            lo++;
            if (lo == 3) ext_low = 1'b0;
            @(negedge clk);
        end
        ext_low = 1'b0;
        check(lo == 14, "R7 restarted low length", lo, 14);

        // R8: slave stretching holds off the high count
        configure(0, 0, 1);
        while (!scl_drive_low) @(negedge clk);
        while (scl_drive_low) @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        ext_low = 1'b1;
        lo = 0;
        while (scl_drive_low && lo < 1000) begin lo++; @(negedge clk); end
        check(lo == 7, "R8 own low unaffected by stretch", lo, 7);
        bad = 0;
        for (int s = 0; s < 6; s++) begin
            if (scl_drive_low || tick_sample) bad++;
            if (s == 5) ext_low = 1'b0;
            @(negedge clk);
        end
        check(bad == 0, "R8 released and silent while held", bad, 0);
        hi = 0; tsc = 0;
        while (!scl_drive_low && hi < 1000) begin
            if (tick_sample) tsc++;
            hi++;
            @(negedge clk);
        end
        check(hi == 7, "R8 high counted after seen high", hi, 7);
        check(tsc == 1, "R10 one sample tick after stretch", tsc, 1);

        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

endmodule